// File: doc/BRIEF.md
# Single-cycle processor control decoder

This block is the hardwired control unit of a 32-bit processor that completes each instruction in one cycle. It is purely combinational. From the 6-bit major opcode, the 6-bit function field and the ALU zero flag, it produces every select and enable the datapath needs in that cycle:

- immediate extension mode
- ALU second-operand source
- ALU operation
- memory and register write enables
- write-back source
- destination-register select
- next-PC source

The supported instructions are:

- register-register ALU operations
- signed and unsigned ALU-immediate operations
- word load and word store
- branch-if-zero and branch-if-nonzero
- absolute jump, with and without link
- register jump, with and without link

The datapath instantiates the block once and wires the instruction bits and the zero flag into it. Every encoding the block does not recognise raises an illegal flag and is turned into a harmless sequential step.

Top module: `ctrl_decode`

Encodings used on the ports:

| Output | Code | Meaning |
|---|---|---|
| `ext_sign` | 1 | sign extension |
| | 0 | zero extension |
| `b_imm` | 1 | immediate as ALU operand B |
| | 0 | register as ALU operand B |
| `alu_op` | 0 | ADD |
| | 1 | SUB |
| | 2 | AND |
| | 3 | OR |
| | 4 | XOR |
| | 5 | NOR |
| | 6 | SLT |
| | 7 | SLTU |
| | 8 | SLL |
| | 9 | SRL |
| | 10 | SRA |
| `wb_sel` | 0 | ALU result |
| | 1 | memory data |
| | 2 | PC link value |
| `dst_sel` | 0 | rt |
| | 1 | rd |
| | 2 | register 31 |
| `pc_sel` | 0 | pc+4 |
| | 1 | branch target |
| | 2 | register-indirect target |
| | 3 | absolute-jump target |

## Requirements
- R1: Opcode 000000 with a function code in the following list writes the ALU result into rd. It sets `b_imm`=0, `reg_we`=1, `mem_we`=0, `wb_sel`=0, `dst_sel`=1 and `pc_sel`=0. The function code picks `alu_op`: 100001→0, 100011→1, 100100→2, 100101→3, 100110→4, 100111→5, 101010→6, 101011→7, 000000→8, 000010→9, 000011→10.
- R2: Signed ALU-immediate opcodes are 001001 (add), 001010 (set-less) and 001011 (set-less unsigned). They give `alu_op` 0, 6 and 7 respectively. They set `ext_sign`=1, `b_imm`=1, `reg_we`=1, `wb_sel`=0 and `dst_sel`=0.
- R3: Unsigned ALU-immediate opcodes are 001100, 001101 and 001110. They give `alu_op` 2, 3 and 4 respectively. They set `ext_sign`=0, `b_imm`=1, `reg_we`=1, `wb_sel`=0 and `dst_sel`=0.
- R4: Load opcode 100011 sets `ext_sign`=1, `b_imm`=1, `alu_op`=0, `reg_we`=1, `mem_we`=0, `wb_sel`=1 and `dst_sel`=0.
- R5: Store opcode 101011 sets `ext_sign`=1, `b_imm`=1, `alu_op`=0, `mem_we`=1 and `reg_we`=0.
- R6: Branch-if-zero (000100) selects `pc_sel`=1 when `zero`=1 and 0 otherwise. Branch-if-nonzero (000101) selects `pc_sel`=1 when `zero`=0 and 0 otherwise. Both use `alu_op`=1 with `b_imm`=0, and neither writes memory or registers.
- R7: Opcode 000010 sets `pc_sel`=3 with no writes. Opcode 000011 also sets `pc_sel`=3, and adds `reg_we`=1, `wb_sel`=2 and `dst_sel`=2.
- R8: Opcode 000000 with function 001000 sets `pc_sel`=2 with no writes. With function 001001 it also sets `pc_sel`=2, and adds `reg_we`=1, `wb_sel`=2 and `dst_sel`=2.
- R9: Any other opcode, or opcode 000000 with any other function code, raises `illegal`. Both write enables are then low and `pc_sel` is 0. `illegal` is low for every recognised instruction.
- R10: A field an instruction does not use takes a fixed value: `ext_sign`=1, `b_imm`=0, `alu_op`=0, `wb_sel`=0, `dst_sel`=0, and `pc_sel`=0 outside jumps and branches. Every output is defined for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode, instruction bits 31:26 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| zero | input | 1 | ALU result equals zero |
| ext_sign | output | 1 | Immediate extension mode |
| b_imm | output | 1 | ALU operand B source |
| alu_op | output | 4 | ALU operation code |
| mem_we | output | 1 | Data memory write enable |
| reg_we | output | 1 | Register file write enable |
| wb_sel | output | 2 | Write-back source |
| dst_sel | output | 2 | Destination register select |
| pc_sel | output | 2 | Next-PC source |
| illegal | output | 1 | Unrecognised instruction |

## Verification
The block has no parameters, so the bench builds it as it stands. Because the input space is only 8192 points, the bench sweeps every opcode, every function code and both zero-flag values. That sweep reaches all legal instructions, both outcomes of each branch, and every unused opcode and function code, each checked against the full output word. Expected words are assembled in the bench from the encodings stated in the requirements.

// File: rtl/ctrl_decode.sv
module ctrl_decode (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       zero,
  output logic       ext_sign,
  output logic       b_imm,
  output logic [3:0] alu_op,
  output logic       mem_we,
  output logic       reg_we,
  output logic [1:0] wb_sel,
  output logic [1:0] dst_sel,
  output logic [1:0] pc_sel,
  output logic       illegal
);

  localparam logic [3:0] A_ADD = 4'd0, A_SUB = 4'd1, A_AND = 4'd2, A_OR  = 4'd3,
                         A_XOR = 4'd4, A_NOR = 4'd5, A_SLT = 4'd6, A_SLTU = 4'd7,
                         A_SLL = 4'd8, A_SRL = 4'd9, A_SRA = 4'd10;
  localparam logic [1:0] WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC = 2'd2;
  localparam logic [1:0] D_RT = 2'd0, D_RD = 2'd1, D_LINK = 2'd2;
  localparam logic [1:0] P_SEQ = 2'd0, P_BR = 2'd1, P_REG = 2'd2, P_ABS = 2'd3;

  logic [3:0] r_op;
  logic       r_ok;

  always_comb begin
    r_ok = 1'b1;
    case (funct)
      6'b100001: r_op = A_ADD;
      6'b100011: r_op = A_SUB;
      6'b100100: r_op = A_AND;
      6'b100101: r_op = A_OR;
      6'b100110: r_op = A_XOR;
      6'b100111: r_op = A_NOR;
      6'b101010: r_op = A_SLT;
      6'b101011: r_op = A_SLTU;
      6'b000000: r_op = A_SLL;
      6'b000010: r_op = A_SRL;
      6'b000011: r_op = A_SRA;
      default: begin r_op = A_ADD; r_ok = 1'b0; end
    endcase
  end

  always_comb begin
    ext_sign = 1'b1;
    b_imm    = 1'b0;
    alu_op   = A_ADD;
    mem_we   = 1'b0;
    reg_we   = 1'b0;
    wb_sel   = WB_ALU;
    dst_sel  = D_RT;
    pc_sel   = P_SEQ;
    illegal  = 1'b0;
    case (opcode)
      6'b000000: begin
        if (funct == 6'b001000) begin
          pc_sel = P_REG;
        end else if (funct == 6'b001001) begin
          pc_sel  = P_REG;
          reg_we  = 1'b1;
          wb_sel  = WB_PC;
          dst_sel = D_LINK;
        end else if (r_ok) begin
          alu_op  = r_op;
          reg_we  = 1'b1;
          dst_sel = D_RD;
        end else begin
          illegal = 1'b1;
        end
      end
      6'b001001, 6'b001010, 6'b001011: begin
        b_imm  = 1'b1;
        reg_we = 1'b1;
        alu_op = (opcode[1:0] == 2'b01) ? A_ADD :
                 (opcode[1:0] == 2'b10) ? A_SLT : A_SLTU;
      end
      6'b001100, 6'b001101, 6'b001110: begin
        ext_sign = 1'b0;
        b_imm    = 1'b1;
        reg_we   = 1'b1;
        alu_op   = (opcode[1:0] == 2'b00) ? A_AND :
                   (opcode[1:0] == 2'b01) ? A_OR : A_XOR;
      end
      6'b100011: begin
        b_imm  = 1'b1;
        reg_we = 1'b1;
        wb_sel = WB_MEM;
      end
      6'b101011: begin
        b_imm  = 1'b1;
        mem_we = 1'b1;
      end
      6'b000100, 6'b000101: begin
        alu_op = A_SUB;
        pc_sel = (zero ^ opcode[0]) ? P_BR : P_SEQ;
      end
      6'b000010: pc_sel = P_ABS;
      6'b000011: begin
        pc_sel  = P_ABS;
        reg_we  = 1'b1;
        wb_sel  = WB_PC;
        dst_sel = D_LINK;
      end
      default: illegal = 1'b1;
    endcase
  end

  always_comb begin
    // R5
    store_no_regwr_chk: assert (!(mem_we && reg_we));
    // R9
    illegal_quiet_chk: assert (!illegal || (!mem_we && !reg_we && pc_sel == P_SEQ));
    // R7
    link_dst_chk: assert (wb_sel != WB_PC || (dst_sel == D_LINK && reg_we));
    // R6
    branch_src_chk: assert (pc_sel != P_BR || opcode[5:1] == 5'b00010);
    // R4
    mem_path_chk: assert (wb_sel != WB_MEM || (b_imm && opcode == 6'b100011));
  end

endmodule

// File: tb/test_ctrl_decode.sv
module test_ctrl_decode;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] opcode = 6'd0, funct = 6'd0;
  logic       zero = 1'b0;
  logic       ext_sign, b_imm, mem_we, reg_we, illegal;
  logic [3:0] alu_op;
  logic [1:0] wb_sel, dst_sel, pc_sel;

  int total = 0, bad = 0;
  int cycles = 0;
  bit done = 0;

  ctrl_decode i_ctrl_decode (
    .opcode(opcode), .funct(funct), .zero(zero),
    .ext_sign(ext_sign), .b_imm(b_imm), .alu_op(alu_op),
    .mem_we(mem_we), .reg_we(reg_we), .wb_sel(wb_sel),
    .dst_sel(dst_sel), .pc_sel(pc_sel), .illegal(illegal)
  );

  function automatic logic [15:0] pack(input logic il, input logic ex, input logic bi,
      input int op, input logic mw, input logic rw, input int wb, input int ds, input int pc);
    return {il, ex, bi, 4'(op), mw, rw, 2'(wb), 2'(ds), 2'(pc)};
  endfunction

  function automatic logic [15:0] expect_of(input int op, input int fn, input int z,
                                           output string tag);
    int rops[11] = '{33, 35, 36, 37, 38, 39, 42, 43, 0, 2, 3};
    tag = "R9";
    expect_of = pack(1, 1, 0, 0, 0, 0, 0, 0, 0);
    if (op == 0) begin
      if (fn == 8) begin tag = "R8"; expect_of = pack(0, 1, 0, 0, 0, 0, 0, 0, 2); end
      else if (fn == 9) begin tag = "R8"; expect_of = pack(0, 1, 0, 0, 0, 1, 2, 2, 2); end
      else
        for (int k = 0; k < 11; k++)
          if (rops[k] == fn) begin tag = "R1"; expect_of = pack(0, 1, 0, k, 0, 1, 0, 1, 0); end
    end
    else if (op >= 9 && op <= 11) begin
      tag = "R2";
      expect_of = pack(0, 1, 1, (op == 9) ? 0 : op - 4, 0, 1, 0, 0, 0);
    end
    else if (op >= 12 && op <= 14) begin
      tag = "R3";
      expect_of = pack(0, 0, 1, op - 10, 0, 1, 0, 0, 0);
    end
    else if (op == 35) begin tag = "R4"; expect_of = pack(0, 1, 1, 0, 0, 1, 1, 0, 0); end
    else if (op == 43) begin tag = "R5"; expect_of = pack(0, 1, 1, 0, 1, 0, 0, 0, 0); end
    else if (op == 4 || op == 5) begin
      tag = "R6";
      expect_of = pack(0, 1, 0, 1, 0, 0, 0, 0, ((op == 4) == (z == 1)) ? 1 : 0);
    end
    else if (op == 2) begin tag = "R7"; expect_of = pack(0, 1, 0, 0, 0, 0, 0, 0, 3); end
    else if (op == 3) begin tag = "R7"; expect_of = pack(0, 1, 0, 0, 0, 1, 2, 2, 3); end
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, exp;
    string tag;
    for (int op = 0; op < 64; op++)
      for (int fn = 0; fn < 64; fn++)
        for (int z = 0; z < 2; z++) begin
          @(posedge clk);
          opcode = 6'(op); funct = 6'(fn); zero = 1'(z);
          @(negedge clk);
          exp = expect_of(op, fn, z, tag);
          got = {illegal, ext_sign, b_imm, alu_op, mem_we, reg_we, wb_sel, dst_sel, pc_sel};
          total++;
          if (got !== exp) begin
            bad++;
            // R10 covered by fixed fields in every expected word
            $display("FAIL %s/R10 op=%b fn=%b z=%0d actual=%h expected=%h",
                     tag, opcode, funct, z, got, exp);
          end
        end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule